// File: doc/BRIEF.md
# Three-Lane Integer Op Allocator

This block sits between decode and the integer execution lanes. Each cycle it is offered up to three decoded integer macro-ops, in program order, in input slots 0 to 2. It places every accepted op in one of three identical execution lanes. Each lane has its own 8-entry scheduling queue. One line is opened in a 24-line reorder buffer for each accepted group. A line has one slot per lane. An op keeps its lane from allocation until its line retires.

A load-op or load-op-store macro-op is still one op here. It takes one queue entry and one line slot. The execution side may issue it more than once, for example an address pass and then an ALU pass; the allocator does not see those passes. Ordinary ops rotate across the lanes. Multiplies always go to lane 0, the only lane with a multiplier. If a multiply cannot get lane 0 in the line being built, the group is split. Only the ops before the multiply are taken, and the multiply is left for a later line.

Back-pressure rules on the input side:
- `in_rdy` is a prefix mask. Slot i is transferred in a cycle when `in_vld[i] && in_rdy[i]`.
- Upstream must present the ops that were not taken again on the next cycle, shifted down to start at slot 0.
- `in_vld` must itself be a prefix (slot 0 first).
- The whole group is held back (`in_rdy` = 0) when the reorder buffer has no free line, or when any lane the group would use has a full queue.

Each lane's issue port is a valid/ready stream. Done reports come back per lane and name a line. The oldest line leaves through a one-cycle retire strobe.

Top module: `tla_dispatch`

## Requirements
- R1: An ordinary (non-multiply) op takes the first lane, counting upward with wrap from the rotation pointer, that is not yet used in the current line. The pointer then moves to the lane after that one. The pointer changes only when a group is accepted, and it is 0 after reset.
- R2: An op with `in_mul` set is only ever placed in lane 0. It is only ever seen on `iss_vld[0]`/`iss_op` bits [OPW-1:0].
- R3: When a multiply meets lane 0 already used in the current line, only the slots before it are accepted. `in_rdy` is always one of 000, 001, 011 or 111.
- R4: When all 24 lines are allocated, `in_rdy` is 000. A retire in the same cycle does not free a line for that cycle.
- R5: When any lane targeted by the group has 8 queued ops, `in_rdy` is 000. An issue from that queue in the same cycle does not make room for that cycle.
- R6: Each lane issues in allocation order. `iss_line` is the line the op was given. Lines are handed out 0,1,…,23,0,… . Valid and data hold until `iss_rdy`.
- R7: The oldest line retires, with `ret_vld` high for one cycle, in the cycle after every occupied slot of that line has reported done. `ret_line` is the line index. `ret_mask` bit l is set when lane l holds an op in that line. Lines retire strictly in allocation order.
- R8: During and right after reset, `iss_vld`, `ret_vld` and `in_rdy` are all 0 while no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 3 | Per-slot op valid, prefix form |
| in_mul | input | 3 | Per-slot multiply flag |
| in_op | input | 3*OPW | Per-slot op payload, slot i at [i*OPW +: OPW] |
| in_rdy | output | 3 | Per-slot accept, prefix form |
| iss_vld | output | 3 | Per-lane queue head valid |
| iss_rdy | input | 3 | Per-lane issue accept |
| iss_op | output | 3*OPW | Per-lane head payload |
| iss_line | output | 3*LINEW | Per-lane head reorder line |
| done_vld | input | 3 | Per-lane completion strobe |
| done_line | input | 3*LINEW | Line of each completion |
| ret_vld | output | 1 | Oldest line retires this cycle |
| ret_line | output | LINEW | Retiring line index |
| ret_mask | output | 3 | Occupied lanes of the retiring line |

## Verification
Two events can land in the same cycle and are checked together:
- allocation of a new line at the tail and retirement of the oldest line;
- a push into a lane queue and an issue out of that same queue.

Both are provoked by filling the buffer with completions held off and then releasing them while groups keep arriving. Long random runs with random issue-ready and completion patterns add more such cycles. A bench model applies the no-bypass rules for full structures. The outputs are compared with that model every cycle, so a design that frees space in the same cycle shows up as a wrong `in_rdy`.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int NLANE = 3;
  localparam int LANEW = $clog2(NLANE);
  typedef logic [LANEW-1:0] lane_t;
endpackage

// File: rtl/tla_steer.sv
module tla_steer
  import tla_pkg::*;
(
  input  logic [NLANE-1:0]            vld,
  input  logic [NLANE-1:0]            mul,
  input  lane_t                       rr,
  output logic [NLANE-1:0]            take,
  output logic [NLANE-1:0][LANEW-1:0] lane,
  output lane_t                       rr_nxt
);
  logic [NLANE-1:0] used;
  lane_t            ptr;
  lane_t            cand;
  lane_t            idx;
  logic             halt;
  logic             hit;

  // R1 rotation with skip of used lanes, R2 multiply pinned, R3 split point
  always_comb begin
    used = '0;
    ptr  = rr;
    halt = 1'b0;
    take = '0;
    lane = '0;
    cand = '0;
    idx  = '0;
    hit  = 1'b0;
    for (int i = 0; i < NLANE; i++) begin
      if (!vld[i]) halt = 1'b1;
      if (!halt) begin
        if (mul[i]) begin
          if (used[0]) begin
            halt = 1'b1;
          end else begin
            take[i] = 1'b1;
            lane[i] = '0;
            used[0] = 1'b1;
          end
        end else begin
          hit  = 1'b0;
          cand = '0;
          for (int k = 0; k < NLANE; k++) begin
            idx = lane_t'((int'(ptr) + k) % NLANE);
            if (!hit && !used[idx]) begin
              hit  = 1'b1;
              cand = idx;
            end
          end
          take[i]    = 1'b1;
          lane[i]    = cand;
          used[cand] = 1'b1;
          ptr        = lane_t'((int'(cand) + 1) % NLANE);
        end
      end
    end
    rr_nxt = ptr;
  end
endmodule

// File: rtl/tla_lane_q.sv
module tla_lane_q #(
  parameter int OPW   = 16,
  parameter int DEPTH = 8,
  parameter int LW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [OPW-1:0] push_op,
  input  logic [LW-1:0]  push_line,
  output logic           full,
  output logic           out_vld,
  input  logic           out_rdy,
  output logic [OPW-1:0] out_op,
  output logic [LW-1:0]  out_line
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [OPW-1:0] op_mem [DEPTH];
  logic [LW-1:0]  ln_mem [DEPTH];
  logic [PW-1:0]  rd_p, wr_p;
  logic [CW-1:0]  cnt;
  logic           pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == CW'(DEPTH));
  assign out_vld  = (cnt != '0);
  assign pop      = out_vld & out_rdy;
  assign out_op   = op_mem[rd_p];
  assign out_line = ln_mem[rd_p];

  always_ff @(posedge clk) begin
    if (push) begin
      op_mem[wr_p] <= push_op;
      ln_mem[wr_p] <= push_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= bump(wr_p);
      if (pop)  rd_p <= bump(rd_p);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R5
  q_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));

  // R6
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_op) && $stable(out_line)));
endmodule

// File: rtl/tla_rob.sv
module tla_rob
  import tla_pkg::*;
#(
  parameter int LINES = 24,
  parameter int LW    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc,
  input  logic [NLANE-1:0]    alloc_mask,
  output logic [LW-1:0]       alloc_line,
  output logic                full,
  input  logic [NLANE-1:0]    done_vld,
  input  logic [NLANE*LW-1:0] done_line,
  output logic                ret_vld,
  output logic [LW-1:0]       ret_line,
  output logic [NLANE-1:0]    ret_mask
);
  localparam int CW = $clog2(LINES + 1);

  logic [NLANE-1:0] occ [LINES];
  logic [NLANE-1:0] fin [LINES];
  logic [LW-1:0]    head, tail;
  logic [CW-1:0]    cnt;

  function automatic logic [LW-1:0] bump(input logic [LW-1:0] p);
    return (p == LW'(LINES - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt == CW'(LINES));
  assign alloc_line = tail;
  assign ret_line   = head;
  assign ret_mask   = occ[head];
  assign ret_vld    = (cnt != '0) && ((fin[head] | ~occ[head]) == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      for (int i = 0; i < LINES; i++) begin
        occ[i] <= '0;
        fin[i] <= '0;
      end
    end else begin
      for (int l = 0; l < NLANE; l++) begin
        if (done_vld[l]) fin[done_line[l*LW +: LW]][l] <= 1'b1;
      end
      if (alloc) begin
        occ[tail] <= alloc_mask;
        fin[tail] <= '0;
        tail      <= bump(tail);
      end
      if (ret_vld) head <= bump(head);
      cnt <= cnt + CW'(alloc) - CW'(ret_vld);
    end
  end

  // R4
  rob_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc);

  // R7
  ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld |=> (ret_line == bump($past(ret_line))));
endmodule

// File: rtl/tla_dispatch.sv
module tla_dispatch
  import tla_pkg::*;
#(
  parameter  int OPW       = 16,
  parameter  int QDEPTH    = 8,
  parameter  int ROB_LINES = 24,
  localparam int LINEW     = $clog2(ROB_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NLANE-1:0]       in_vld,
  input  logic [NLANE-1:0]       in_mul,
  input  logic [NLANE*OPW-1:0]   in_op,
  output logic [NLANE-1:0]       in_rdy,
  output logic [NLANE-1:0]       iss_vld,
  input  logic [NLANE-1:0]       iss_rdy,
  output logic [NLANE*OPW-1:0]   iss_op,
  output logic [NLANE*LINEW-1:0] iss_line,
  input  logic [NLANE-1:0]       done_vld,
  input  logic [NLANE*LINEW-1:0] done_line,
  output logic                   ret_vld,
  output logic [LINEW-1:0]       ret_line,
  output logic [NLANE-1:0]       ret_mask
);
  lane_t                       rr_q, rr_nxt;
  logic [NLANE-1:0]            take;
  logic [NLANE-1:0][LANEW-1:0] lane;
  logic [NLANE-1:0]            tgt;
  logic [NLANE-1:0]            q_full;
  logic [NLANE-1:0]            q_push;
  logic [NLANE-1:0][OPW-1:0]   q_op;
  logic [LINEW-1:0]            new_line;
  logic                        rob_full;
  logic                        stall;
  logic                        alloc;

  tla_steer u_steer (
    .vld    (in_vld),
    .mul    (in_mul),
    .rr     (rr_q),
    .take   (take),
    .lane   (lane),
    .rr_nxt (rr_nxt)
  );

  always_comb begin
    tgt  = '0;
    q_op = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (take[i]) begin
        tgt[lane[i]]  = 1'b1;
        q_op[lane[i]] = in_op[i*OPW +: OPW];
      end
    end
  end

  // R4 and R5: whole-group stall, no same-cycle bypass of freed space
  assign stall  = rob_full | (|(tgt & q_full));
  assign in_rdy = stall ? '0 : take;
  assign alloc  = (|take) & ~stall;
  assign q_push = alloc ? tgt : '0;

  // R1 rotation pointer advances only on an accepted group
  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (alloc) rr_q <= rr_nxt;
  end

  tla_rob #(.LINES(ROB_LINES), .LW(LINEW)) u_rob (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (alloc),
    .alloc_mask (tgt),
    .alloc_line (new_line),
    .full       (rob_full),
    .done_vld   (done_vld),
    .done_line  (done_line),
    .ret_vld    (ret_vld),
    .ret_line   (ret_line),
    .ret_mask   (ret_mask)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    tla_lane_q #(.OPW(OPW), .DEPTH(QDEPTH), .LW(LINEW)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[g]),
      .push_op   (q_op[g]),
      .push_line (new_line),
      .full      (q_full[g]),
      .out_vld   (iss_vld[g]),
      .out_rdy   (iss_rdy[g]),
      .out_op    (iss_op[g*OPW +: OPW]),
      .out_line  (iss_line[g*LINEW +: LINEW])
    );

    // R2
    mul_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld[g] && in_rdy[g] && in_mul[g]) |-> (q_push[0] && q_op[0] == in_op[g*OPW +: OPW]));
  end

  // R3
  rdy_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy == 3'b000 || in_rdy == 3'b001 || in_rdy == 3'b011 || in_rdy == 3'b111));

  // R1
  rr_spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy == 3'b111 && in_mul == 3'b000) |-> (q_push == 3'b111));
endmodule

// File: tb/tla_dispatch_tb.sv
module tla_dispatch_tb;
  import tla_pkg::*;
  localparam int OPW = 16;
  localparam int QD  = 8;
  localparam int RL  = 24;
  localparam int LW  = $clog2(RL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]       in_vld, in_mul, in_rdy, iss_vld, iss_rdy, done_vld, ret_mask;
  logic [3*OPW-1:0] in_op, iss_op;
  logic [3*LW-1:0]  iss_line, done_line;
  logic             ret_vld;
  logic [LW-1:0]    ret_line;

  tla_dispatch #(.OPW(OPW), .QDEPTH(QD), .ROB_LINES(RL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mul(in_mul), .in_op(in_op),
    .in_rdy(in_rdy), .iss_vld(iss_vld), .iss_rdy(iss_rdy), .iss_op(iss_op),
    .iss_line(iss_line), .done_vld(done_vld), .done_line(done_line),
    .ret_vld(ret_vld), .ret_line(ret_line), .ret_mask(ret_mask)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [OPW-1:0] mq_op [3][QD];
  logic [LW-1:0]  mq_ln [3][QD];
  int             mq_h [3];
  int             mq_n [3];
  logic [2:0]     m_occ [RL];
  logic [2:0]     m_dn  [RL];
  int             m_head, m_tail, m_cnt, m_rr;
  int             pd_ln [3][32];
  int             pd_h [3];
  int             pd_n [3];
  int             opseq = 0;

  // expected steering
  logic [2:0] e_take;
  int         e_lane [3];
  int         e_rr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Lanes are filled in program order; a multiply needs lane 0 free in the line,
  // an ordinary op searches upward from the pointer for a free lane.
  task automatic plan_group(input logic [2:0] v, input logic [2:0] m);
    bit taken [3];
    bit stop;
    int p;
    for (int l = 0; l < 3; l++) taken[l] = 0;
    stop = 0;
    p = m_rr;
    e_take = 3'b000;
    for (int s = 0; s < 3; s++) begin
      e_lane[s] = 0;
      if (!v[s]) stop = 1;
      if (!stop && m[s]) begin
        if (taken[0]) stop = 1;
        else begin e_take[s] = 1'b1; e_lane[s] = 0; taken[0] = 1; end
      end else if (!stop) begin
        int c = p;
        while (taken[c]) c = (c + 1) % 3;
        e_take[s] = 1'b1; e_lane[s] = c; taken[c] = 1; p = (c + 1) % 3;
      end
    end
    e_rr = p;
  endtask

  task automatic cycle(input logic [2:0] v, input logic [2:0] m,
                       input logic [2:0] irdy, input logic [2:0] dreq);
    logic [2:0] e_rdy;
    logic [2:0] mask;
    bit rob_stall, q_stall, e_ret;
    string tag;
    @(negedge clk);
    in_vld = v; in_mul = m; iss_rdy = irdy;
    for (int s = 0; s < 3; s++) begin
      in_op[s*OPW +: OPW] = {m[s], 15'(opseq + s)};
    end
    done_vld = 3'b000; done_line = '0;
    for (int l = 0; l < 3; l++) begin
      if (dreq[l] && pd_n[l] > 0) begin
        done_vld[l] = 1'b1;
        done_line[l*LW +: LW] = LW'(pd_ln[l][pd_h[l]]);
      end
    end
    #1;
    plan_group(v, m);
    rob_stall = (m_cnt == RL);
    q_stall = 0;
    mask = 3'b000;
    for (int s = 0; s < 3; s++) begin
      if (e_take[s]) begin
        mask[e_lane[s]] = 1'b1;
        if (mq_n[e_lane[s]] == QD) q_stall = 1;
      end
    end
    e_rdy = (rob_stall || q_stall) ? 3'b000 : e_take;
    if (rob_stall && e_take != 0) tag = "R4";
    else if (q_stall) tag = "R5";
    else if (e_take != v) tag = "R3";
    else if (m != 0) tag = "R2";
    else tag = "R1";
    chk(in_rdy == e_rdy, tag, "in_rdy", in_rdy, e_rdy);
    for (int l = 0; l < 3; l++) begin
      chk(iss_vld[l] == (mq_n[l] > 0), "R6", "iss_vld", iss_vld[l], mq_n[l] > 0);
      if (mq_n[l] > 0) begin
        chk(iss_op[l*OPW +: OPW] == mq_op[l][mq_h[l]], "R6", "iss_op",
            iss_op[l*OPW +: OPW], mq_op[l][mq_h[l]]);
        chk(iss_line[l*LW +: LW] == mq_ln[l][mq_h[l]], "R6", "iss_line",
            iss_line[l*LW +: LW], mq_ln[l][mq_h[l]]);
      end
      if (iss_vld[l] && iss_op[l*OPW + OPW - 1]) chk(l == 0, "R2", "mul lane", l, 0);
    end
    e_ret = (m_cnt > 0) && ((m_dn[m_head] | ~m_occ[m_head]) == 3'b111);
    chk(ret_vld == e_ret, "R7", "ret_vld", ret_vld, e_ret);
    if (e_ret) begin
      chk(ret_line == LW'(m_head), "R7", "ret_line", ret_line, m_head);
      chk(ret_mask == m_occ[m_head], "R7", "ret_mask", ret_mask, m_occ[m_head]);
    end
    // model update for the coming edge
    if (e_ret) begin m_head = (m_head + 1) % RL; m_cnt--; end
    for (int l = 0; l < 3; l++) begin
      if (done_vld[l]) begin
        m_dn[pd_ln[l][pd_h[l]]][l] = 1'b1;
        pd_h[l] = (pd_h[l] + 1) % 32; pd_n[l]--;
      end
      if (irdy[l] && mq_n[l] > 0) begin
        pd_ln[l][(pd_h[l] + pd_n[l]) % 32] = int'(mq_ln[l][mq_h[l]]);
        pd_n[l]++;
        mq_h[l] = (mq_h[l] + 1) % QD; mq_n[l]--;
      end
    end
    if (e_rdy != 0) begin
      for (int s = 0; s < 3; s++) begin
        if (e_take[s]) begin
          int l = e_lane[s];
          int w = (mq_h[l] + mq_n[l]) % QD;
          mq_op[l][w] = in_op[s*OPW +: OPW];
          mq_ln[l][w] = LW'(m_tail);
          mq_n[l]++;
        end
      end
      m_occ[m_tail] = mask; m_dn[m_tail] = 3'b000;
      m_tail = (m_tail + 1) % RL; m_cnt++;
      m_rr = e_rr;
    end
    opseq += 3;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    in_vld = 0; in_mul = 0; in_op = 0; iss_rdy = 0; done_vld = 0; done_line = 0;
    for (int l = 0; l < 3; l++) begin mq_h[l] = 0; mq_n[l] = 0; pd_h[l] = 0; pd_n[l] = 0; end
    for (int i = 0; i < RL; i++) begin m_occ[i] = 0; m_dn[i] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0; m_rr = 0;
    // R8 reset state
    repeat (3) @(negedge clk);
    #1;
    chk(iss_vld == 3'b000, "R8", "iss_vld in reset", iss_vld, 0);
    chk(ret_vld == 1'b0, "R8", "ret_vld in reset", ret_vld, 0);
    chk(in_rdy == 3'b000, "R8", "in_rdy in reset", in_rdy, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(iss_vld == 3'b000 && ret_vld == 1'b0, "R8", "idle after reset", {iss_vld, ret_vld}, 0);
    // directed: spread, split on mul at slot 2, leftover mul, back-to-back muls
    cycle(3'b111, 3'b000, 3'b000, 3'b000);
    cycle(3'b111, 3'b100, 3'b000, 3'b000);
    cycle(3'b011, 3'b001, 3'b000, 3'b000);
    cycle(3'b111, 3'b011, 3'b000, 3'b000);
    // lane queues fill (R5)
    repeat (12) cycle(3'b111, 3'b000, 3'b000, 3'b000);
    // issue freely with completions held: reorder buffer fills (R4)
    repeat (40) cycle(3'b111, 3'b000, 3'b111, 3'b000);
    // release completions while still allocating: retire and allocate together
    repeat (30) cycle(3'b111, 3'b001, 3'b111, 3'b111);
    repeat (60) cycle(3'b000, 3'b000, 3'b111, 3'b111);
    // constrained random
    for (int c = 0; c < 4000; c++) begin
      int n = $urandom % 4;
      int mode = (c / 250) % 3;
      logic [2:0] v = 3'((1 << n) - 1);
      logic [2:0] m = 0;
      logic [2:0] ir, dr;
      for (int s = 0; s < 3; s++) m[s] = ($urandom % 10) < 3;
      ir = 3'($urandom);
      dr = 3'($urandom);
      if (mode == 1) ir = ir & 3'($urandom) & 3'($urandom);
      if (mode == 2) dr = dr & 3'($urandom) & 3'($urandom);
      cycle(v, m, ir, dr);
    end
    repeat (120) cycle(3'b000, 3'b000, 3'b111, 3'b111);
    chk(m_cnt == 0, "R7", "buffer drained", m_cnt, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule